// File: doc/BRIEF.md
# Deferred-Carry Wide Decimal Adder

This block adds two wide packed-BCD operands (68 decimal digits by default) at a fast clock. It does not let a carry ripple across the whole word. Instead, the word is divided into segments of two digits each. Every segment adds on its own, and the carry leaving each segment is stored in a flop. On the next clock, that stored carry is added into the segment above it, while the rest of the partial sum is held.

The adder repeats these passes until a pass produces no new carry between segments. Random operands usually finish in one or two clocks. The carry that leaves the top segment is folded into a sticky carry-out. Inside each digit, decimal correction comes from a small 20-entry lookup table indexed by the 5-bit binary digit sum. No magnitude comparison is used.

The controller has two states:
- `ST_IDLE` waits for `start`. On `start` it runs the first pass. It stays in `ST_IDLE` if no carry crosses between segments, and otherwise moves to `ST_RESOLVE`.
- `ST_RESOLVE` runs one carry pass per clock. It goes back to `ST_IDLE` on the first pass that leaves no carry between segments.

Each move into `ST_IDLE` that ends an operation raises `done` for one cycle.

Top module: `dbcd_adder`

## Requirements
- R1: When `done` is high, `sum` holds (A + B + cin) mod 10^DIGITS as packed BCD. Digit i is in bits [4i+3:4i], with digit 0 the least significant, and every digit is 0 to 9.
- R2: `cin` (1 bit, sampled with `start`) adds one unit to digit 0.
- R3: When `done` is high, `cout` is 1 exactly when A + B + cin is at least 10^DIGITS. It is accumulated, so it never falls during carry passes.
- R4: If no segment's first-pass two-digit sum (operand digits plus `cin` for segment 0) reaches 100, `done` is high in the first cycle after the clock edge that samples `start`.
- R5: Each further clock adds every stored segment carry into the segment above it. When a carry enters a segment whose partial sum is 99 (and that segment is not the top one), a new carry is stored for the next pass. `done` follows the last pass by one cycle, and no carry is pending when `done` is high.
- R6: The latency from the start edge to `done` is 1 plus the longest carry chain. It is never more than NSEG = DIGITS/2 cycles. The worst case is all nines plus zero with `cin`=1.
- R7: `done` is a one-cycle pulse. `sum` and `cout` keep their values after it until the next accepted `start`.
- R8: A `start` that arrives while carry passes are still pending is ignored. It has no effect on the result or on the latency.
- R9: After reset, `sum` is all zeros, `cout` is 0 and `done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an addition; operands and cin are sampled on this edge |
| cin | input | 1 | Decimal carry into digit 0 |
| opnd_a | input | DIGITS*4 | Packed-BCD operand A |
| opnd_b | input | DIGITS*4 | Packed-BCD operand B |
| sum | output | DIGITS*4 | Packed-BCD result |
| cout | output | 1 | Decimal carry out of the top digit |
| done | output | 1 | One-cycle pulse: result is valid |

## Verification
The result and the carry-out are both due in the cycle in which `done` is high. That cycle is 1 + L cycles after the edge that samples `start`. Here L is the longest carry chain, and the bench derives L from the operands' two-digit segment sums (R4, R5, R6).

The bench drives inputs and samples outputs on the falling edge. It counts falling edges from the start edge until `done` appears, and compares that count with the predicted latency. It checks `sum` and `cout` in that same cycle, checks again one cycle later that `done` has dropped and the values are held, and injects an ignored `start` partway through a long carry chain.

// File: rtl/dbcd_pkg.sv
package dbcd_pkg;

    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_RESOLVE = 1'b1
    } dbcd_state_e;

    // Decimal correction table: binary digit sum 0..19 -> {carry, digit}.
    function automatic logic [4:0] dec_fix(input logic [4:0] raw);
        logic [4:0] r;
        unique case (raw)
            5'd0:  r = {1'b0, 4'd0};   5'd1:  r = {1'b0, 4'd1};
            5'd2:  r = {1'b0, 4'd2};   5'd3:  r = {1'b0, 4'd3};
            5'd4:  r = {1'b0, 4'd4};   5'd5:  r = {1'b0, 4'd5};
            5'd6:  r = {1'b0, 4'd6};   5'd7:  r = {1'b0, 4'd7};
            5'd8:  r = {1'b0, 4'd8};   5'd9:  r = {1'b0, 4'd9};
            5'd10: r = {1'b1, 4'd0};   5'd11: r = {1'b1, 4'd1};
            5'd12: r = {1'b1, 4'd2};   5'd13: r = {1'b1, 4'd3};
            5'd14: r = {1'b1, 4'd4};   5'd15: r = {1'b1, 4'd5};
            5'd16: r = {1'b1, 4'd6};   5'd17: r = {1'b1, 4'd7};
            5'd18: r = {1'b1, 4'd8};   5'd19: r = {1'b1, 4'd9};
            default: r = {1'b1, raw[3:0] + 4'd6};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dbcd_seg.sv
module dbcd_seg
    import dbcd_pkg::*;
#(
    parameter int SEG_DIGITS = 2
) (
    input  logic [SEG_DIGITS*4-1:0] x,
    input  logic [SEG_DIGITS*4-1:0] y,
    input  logic                    ci,
    output logic [SEG_DIGITS*4-1:0] s,
    output logic                    co
);
    logic [SEG_DIGITS:0] chain;

    assign chain[0] = ci;

    for (genvar d = 0; d < SEG_DIGITS; d++) begin : g_dig
        logic [4:0] raw;
        logic [4:0] fixed;
        always_comb begin
            raw   = {1'b0, x[d*4 +: 4]} + {1'b0, y[d*4 +: 4]} + {4'd0, chain[d]};
            fixed = dec_fix(raw);
        end
        assign s[d*4 +: 4] = fixed[3:0];
        assign chain[d+1]  = fixed[4];
    end

    assign co = chain[SEG_DIGITS];
endmodule

// File: rtl/dbcd_lanes.sv
module dbcd_lanes #(
    parameter int DIGITS     = 68,
    parameter int SEG_DIGITS = 2,
    localparam int NSEG      = DIGITS / SEG_DIGITS,
    localparam int SEGW      = SEG_DIGITS * 4,
    localparam int W         = DIGITS * 4
) (
    input  logic [W-1:0]    opx,
    input  logic [W-1:0]    opy,
    input  logic [NSEG-1:0] cvec_in,
    output logic [W-1:0]    sum,
    output logic [NSEG-1:0] cvec_out
);
    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        dbcd_seg #(.SEG_DIGITS(SEG_DIGITS)) u_seg (
            .x  (opx[g*SEGW +: SEGW]),
            .y  (opy[g*SEGW +: SEGW]),
            .ci (cvec_in[g]),
            .s  (sum[g*SEGW +: SEGW]),
            .co (cvec_out[g])
        );
    end
endmodule

// File: rtl/dbcd_ctrl.sv
module dbcd_ctrl
    import dbcd_pkg::*;
#(
    parameter int NSEG = 34,
    localparam int CW  = $clog2(NSEG) + 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic carry_zero,
    output logic first,
    output logic pass,
    output logic done
);
    dbcd_state_e state, state_nx;
    logic [CW-1:0] pass_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (start) state_nx = carry_zero ? ST_IDLE : ST_RESOLVE;
            ST_RESOLVE: state_nx = carry_zero ? ST_IDLE : ST_RESOLVE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    assign first = (state == ST_IDLE) && start;
    assign pass  = (state == ST_RESOLVE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done     <= 1'b0;
            pass_cnt <= '0;
        end else begin
            done <= (first || pass) && carry_zero;
            if (first)     pass_cnt <= '0;
            else if (pass) pass_cnt <= pass_cnt + 1'b1;
        end
    end

    AST_PASS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        pass_cnt <= CW'(NSEG - 1)); // R6

    AST_PASS_HOLDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        pass |-> !first); // R8
endmodule

// File: rtl/dbcd_adder.sv
module dbcd_adder #(
    parameter int DIGITS     = 68,
    parameter int SEG_DIGITS = 2,
    localparam int NSEG      = DIGITS / SEG_DIGITS,
    localparam int W         = DIGITS * 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         cin,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         done
);
    logic [W-1:0]    acc_q;
    logic [NSEG-2:0] pend_q;
    logic            cout_q;
    logic            first, pass, carry_zero;
    logic [W-1:0]    opx, opy, lane_sum;
    logic [NSEG-1:0] cv_in, cv_out;

    always_comb begin
        if (first) begin
            opx   = opnd_a;
            opy   = opnd_b;
            cv_in = {{(NSEG-1){1'b0}}, cin};
        end else begin
            opx   = acc_q;
            opy   = '0;
            cv_in = {pend_q, 1'b0};
        end
    end

    dbcd_lanes #(.DIGITS(DIGITS), .SEG_DIGITS(SEG_DIGITS)) u_lanes (
        .opx      (opx),
        .opy      (opy),
        .cvec_in  (cv_in),
        .sum      (lane_sum),
        .cvec_out (cv_out)
    );

    assign carry_zero = ~|cv_out[NSEG-2:0];

    dbcd_ctrl #(.NSEG(NSEG)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .carry_zero (carry_zero),
        .first      (first),
        .pass       (pass),
        .done       (done)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            pend_q <= '0;
            cout_q <= 1'b0;
        end else if (first || pass) begin
            acc_q  <= lane_sum;
            pend_q <= cv_out[NSEG-2:0];
            cout_q <= first ? cv_out[NSEG-1] : (cout_q | cv_out[NSEG-1]);
        end
    end

    assign sum  = acc_q;
    assign cout = cout_q;

    logic [DIGITS-1:0] dig_ok;
    always_comb begin
        for (int i = 0; i < DIGITS; i++) dig_ok[i] = (acc_q[i*4 +: 4] <= 4'd9);
    end

    AST_DIGITS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> &dig_ok); // R1

    AST_DONE_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (pend_q == '0)); // R5

    AST_COUT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cout_q) |-> $past(first)); // R3

    AST_HOLD_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !first) |=> $stable(acc_q) && $stable(cout_q)); // R7
endmodule

// File: tb/sim_dbcd_adder.sv
module sim_dbcd_adder;
    localparam int DIGITS = 68;
    localparam int NSEG   = DIGITS / 2;
    localparam int W      = DIGITS * 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic cin = 1'b0;
    logic [W-1:0] a = '0, b = '0;
    logic [W-1:0] sum;
    logic cout, done;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    dbcd_adder #(.DIGITS(DIGITS)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .cin(cin),
        .opnd_a(a), .opnd_b(b), .sum(sum), .cout(cout), .done(done)
    );

    function automatic logic [W:0] ref_add(input logic [W-1:0] x, input logic [W-1:0] y, input logic c);
        logic [W-1:0] r;
        int cr;
        cr = c;
        for (int i = 0; i < DIGITS; i++) begin
            int t;
            t = int'(x[i*4 +: 4]) + int'(y[i*4 +: 4]) + cr;
            cr = (t >= 10) ? 1 : 0;
            r[i*4 +: 4] = 4'(t % 10);
        end
        return {cr[0], r};
    endfunction

    // Latency: 1 + longest chain (a carry from a segment, then one more pass per 99 segment below the top).
    function automatic int ref_lat(input logic [W-1:0] x, input logic [W-1:0] y, input logic c);
        int p[NSEG];
        bit g[NSEG];
        int best;
        best = 0;
        for (int s = 0; s < NSEG; s++) begin
            int v;
            v = 10*int'(x[s*8+4 +: 4]) + int'(x[s*8 +: 4]) + 10*int'(y[s*8+4 +: 4]) + int'(y[s*8 +: 4]);
            if (s == 0) v += c;
            g[s] = (v >= 100);
            p[s] = v % 100;
        end
        for (int s = 0; s < NSEG-1; s++) begin
            if (g[s]) begin
                int len, k;
                len = 1;
                k = s + 1;
                while (k < NSEG-1 && p[k] == 99) begin len++; k++; end
                if (len > best) best = len;
            end
        end
        return 1 + best;
    endfunction

    function automatic logic [W-1:0] rnd_bcd();
        logic [W-1:0] r;
        for (int i = 0; i < DIGITS; i++) r[i*4 +: 4] = 4'($urandom % 10);
        return r;
    endfunction

    function automatic logic [W-1:0] fill(input logic [3:0] d);
        logic [W-1:0] r;
        for (int i = 0; i < DIGITS; i++) r[i*4 +: 4] = d;
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input string what, input logic [W:0] act, input logic [W:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // inject > 0: pulse a foreign start at that many cycles after the start edge.
    task automatic run_op(input logic [W-1:0] x, input logic [W-1:0] y, input logic c, input int inject, input string req);
        logic [W:0] exp;
        int lat, elat;
        exp  = ref_add(x, y, c);
        elat = ref_lat(x, y, c);
        @(negedge clk);
        a = x; b = y; cin = c; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < NSEG + 8) begin
            if (lat == inject) begin a = fill(4'd3); b = fill(4'd4); cin = 1'b0; start = 1'b1; end
            @(negedge clk);
            start = 1'b0;
            lat++;
        end
        check(lat == elat, req, "latency", (W+1)'(lat), (W+1)'(elat));
        check(sum == exp[W-1:0], req, "sum", {1'b0, sum}, {1'b0, exp[W-1:0]});
        check(cout == exp[W], req, "cout", (W+1)'(cout), (W+1)'(exp[W]));
        @(negedge clk);
        check(!done && sum == exp[W-1:0] && cout == exp[W], "R7", "pulse/hold",
              {done, sum}, {1'b0, exp[W-1:0]});
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(sum == '0 && !cout && !done, "R9", "reset state", {cout, sum}, '0);
        rst_n = 1'b1;
        // R4: no inter-segment carries
        run_op(fill(4'd1), fill(4'd2), 1'b0, 0, "R4");
        run_op('0, '0, 1'b0, 0, "R4");
        // R2: carry-in alone
        run_op('0, '0, 1'b1, 0, "R2");
        // R5: a single carry into segment 1
        run_op({{(W-8){1'b0}}, 8'h60}, {{(W-8){1'b0}}, 8'h55}, 1'b0, 0, "R5");
        // R3: all nines plus all nines
        run_op(fill(4'd9), fill(4'd9), 1'b0, 0, "R3");
        run_op(fill(4'd9), fill(4'd9), 1'b1, 0, "R3");
        // R6: worst-case chain
        run_op(fill(4'd9), '0, 1'b1, 0, "R6");
        // R8: start during passes is ignored
        run_op(fill(4'd9), '0, 1'b1, 5, "R8");
        // R5: chain of 99 segments starting mid-word
        run_op({{(W-80){1'b0}}, 80'h99999999999999999950}, {{(W-80){1'b0}}, 80'h50}, 1'b0, 0, "R5");
        // R1: random operands
        for (int k = 0; k < 40; k++) run_op(rnd_bcd(), rnd_bcd(), 1'($urandom % 2), 0, "R1");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule